// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One channel of a programmable interval timer. A 16-bit down-counter steps once for each rising edge of a slow count clock, and only while a gate input is high. The count clock runs asynchronously to the system clock, so it is passed through a synchronizer and turned into a one-cycle step enable. All state lives in the system clock domain.

Three operating modes set how the OUT waveform behaves and whether the counter reloads. The one-shot mode raises OUT once when the count reaches zero. The rate mode gives a one-step low pulse once per period. The square mode divides the count clock by n. A one-cycle interrupt pulse marks each terminal count. The count runs in plain binary or in four-decade BCD. The live count is always visible on an output. Bus decoding and count latching for readback live outside the block.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, outSig is 1, tcIrq is 0 and countVal is 0. No step takes place until the first load.
- R2: A step happens only for a rising edge of cntClkIn, seen after a 2-flop synchronizer and one edge-detect flop, while gateIn is 1. When gateIn is 0, countVal holds.
- R3: A loaded count of 0 means 65536 steps in binary and 10000 steps in BCD. The square mode's first half-phase value for a binary 0 is 16'h8000.
- R4: modeSel 2'd0 (one-shot): a load sets countVal to the value and outSig to 0 on the next clock. The step that reaches 0 sets outSig to 1 and pulses tcIrq once. Counting then continues with wrap (0 to 16'hFFFF in binary, 0 to 16'h9999 in BCD), and outSig stays 1.
- R5: modeSel 2'd1 (rate; 2'd3 behaves the same): the step to count 1 drives outSig to 0. The next step reloads the initial value, drives outSig to 1 and pulses tcIrq, so the period is n steps.
- R6: modeSel 2'd2 (square): outSig starts at 1. The high half lasts ceil(n/2) steps and the low half floor(n/2). countVal holds the half-phase count, which starts at floor(n/2). tcIrq pulses together with each rise of outSig.
- R7: When bcdSel is 1, each 4-bit digit steps down from 9 to 0 and borrows from the digit above it. Every digit of countVal stays at 9 or below.
- R8: In the rate and square modes, a load after the first one only changes the initial value. That value takes effect at the next reload, and counting goes on without a break. The first load after reset starts counting at once.
- R9: In one-shot mode, every load restarts the count at once and drives outSig low. A load takes priority over a step in the same cycle.
- R10: tcIrq is never high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntClkIn | input | 1 | Asynchronous count clock |
| gateIn | input | 1 | Count enable |
| modeSel | input | 2 | 0 one-shot, 1 rate, 2 square, 3 rate |
| bcdSel | input | 1 | 1 selects four-decade BCD counting |
| loadValue | input | 16 | Initial count |
| loadStb | input | 1 | One-cycle load strobe |
| outSig | output | 1 | Mode waveform |
| tcIrq | output | 1 | One-cycle terminal-count pulse |
| countVal | output | 16 | Live count |

## Verification
The assertions take three things as given. modeSel and bcdSel change only while reset is held. Loaded values are valid BCD whenever bcdSel is 1. Counts of 1 are not loaded in the rate or square modes. The stimulus follows these rules by resetting before each change of mode or number format and by choosing counts of at least 2 for the periodic modes. The count clock is driven at four system clocks per period, so each step is seen and two interrupt pulses can never fall on adjacent cycles.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2,
    MODE_RATE2   = 2'd3
  } itc_mode_e;

  typedef struct packed {
    logic capInit;
    logic startFull;
    logic startHalf;
    logic reloadFull;
    logic reloadHalf;
    logic stepDown;
  } itc_cmd_t;
endpackage

// File: rtl/itc_tick_gen.sv
module itc_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cntClkIn,
  output logic tickEn
);
  localparam int CHAIN_W = SYNC_STAGES + 1;
  logic [CHAIN_W-1:0] chainQ;

  always_ff @(posedge clk) begin
    if (!rstN) chainQ <= '0;
    else       chainQ <= {chainQ[CHAIN_W-2:0], cntClkIn};
  end

  // rising edge seen between the last sync flop and the history flop
  assign tickEn = chainQ[SYNC_STAGES-1] & ~chainQ[SYNC_STAGES];
endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  itc_cmd_t         cmd,
  input  logic             bcdSel,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] countQ,
  output logic             countIsOne,
  output logic             countIsTwo,
  output logic             initOdd
);
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] BIN_ZERO_HALF = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] BCD_ZERO_HALF = CNT_W'(5) << (CNT_W - 4);

  logic [CNT_W-1:0] initQ;
  logic [CNT_W-1:0] decVal;
  logic [CNT_W-1:0] halfLoad;
  logic [CNT_W-1:0] halfInit;

  function automatic logic [CNT_W-1:0] bcdDec(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] halfOf(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic [4:0] acc;
    logic rem;
    r = '0;
    rem = 1'b0;
    if (v == '0) r = bcd ? BCD_ZERO_HALF : BIN_ZERO_HALF;
    else if (!bcd) r = v >> 1;
    else begin
      for (int d = DIGITS - 1; d >= 0; d--) begin
        acc = (rem ? 5'd10 : 5'd0) + {1'b0, v[d*4 +: 4]};
        r[d*4 +: 4] = acc[4:1];
        rem = acc[0];
      end
    end
    return r;
  endfunction

  assign decVal   = bcdSel ? bcdDec(countQ) : countQ - CNT_W'(1);
  assign halfLoad = halfOf(loadValue, bcdSel);
  assign halfInit = halfOf(initQ, bcdSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      initQ  <= '0;
    end else begin
      if (cmd.capInit) initQ <= loadValue;
      if (cmd.startFull)       countQ <= loadValue;
      else if (cmd.startHalf)  countQ <= halfLoad;
      else if (cmd.reloadFull) countQ <= initQ;
      else if (cmd.reloadHalf) countQ <= halfInit;
      else if (cmd.stepDown)   countQ <= decVal;
    end
  end

  assign countIsOne = (countQ == CNT_W'(1));
  assign countIsTwo = (countQ == CNT_W'(2));
  assign initOdd    = initQ[0];

  // R7: every decade stays a legal digit in BCD counting
  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digitChk
      a_r7_bcd_digit: assert property (@(posedge clk) disable iff (!rstN)
        bcdSel |-> (countQ[g*4 +: 4] <= 4'd9));
    end
  endgenerate
endmodule

// File: rtl/itc_control.sv
module itc_control
  import itc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      gateIn,
  input  itc_mode_e mode,
  input  logic      loadStb,
  input  logic      loadOdd,
  input  logic      countIsOne,
  input  logic      countIsTwo,
  input  logic      initOdd,
  output itc_cmd_t  cmd,
  output logic      outSig,
  output logic      tcIrq
);
  logic startedQ, outQ, oddPendQ, irqQ;
  logic startedN, outN, oddPendN, irqN;
  logic immLoad, stepEn;

  assign immLoad = loadStb && (mode == MODE_ONESHOT || !startedQ);
  assign stepEn  = tickEn && gateIn && startedQ;

  always_comb begin
    cmd         = '0;
    cmd.capInit = loadStb;
    startedN    = startedQ;
    outN        = outQ;
    oddPendN    = oddPendQ;
    irqN        = 1'b0;
    if (immLoad) begin
      startedN = 1'b1;
      if (mode == MODE_SQUARE) begin
        cmd.startHalf = 1'b1;
        oddPendN      = loadOdd;
        outN          = 1'b1;
      end else begin
        cmd.startFull = 1'b1;
        outN          = (mode != MODE_ONESHOT);
      end
    end else if (stepEn) begin
      unique case (mode)
        MODE_ONESHOT: begin
          cmd.stepDown = 1'b1;
          if (countIsOne && !outQ) begin
            outN = 1'b1;
            irqN = 1'b1;
          end
        end
        MODE_SQUARE: begin
          if (!countIsOne) cmd.stepDown = 1'b1;
          else if (outQ && oddPendQ) oddPendN = 1'b0;
          else if (outQ) begin
            outN           = 1'b0;
            cmd.reloadHalf = 1'b1;
          end else begin
            outN           = 1'b1;
            cmd.reloadHalf = 1'b1;
            oddPendN       = initOdd;
            irqN           = 1'b1;
          end
        end
        default: begin
          if (countIsOne) begin
            cmd.reloadFull = 1'b1;
            outN           = 1'b1;
            irqN           = 1'b1;
          end else begin
            cmd.stepDown = 1'b1;
            if (countIsTwo) outN = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startedQ <= 1'b0;
      outQ     <= 1'b1;
      oddPendQ <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      startedQ <= startedN;
      outQ     <= outN;
      oddPendQ <= oddPendN;
      irqQ     <= irqN;
    end
  end

  assign outSig = outQ;
  assign tcIrq  = irqQ;

  // R10: terminal-count pulse lasts a single clock
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ);
  // R1: nothing moves before the first load
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!startedQ && !loadStb) |=> (outQ && !irqQ));
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntClkIn,
  input  logic             gateIn,
  input  logic [1:0]       modeSel,
  input  logic             bcdSel,
  input  logic [CNT_W-1:0] loadValue,
  input  logic             loadStb,
  output logic             outSig,
  output logic             tcIrq,
  output logic [CNT_W-1:0] countVal
);
  itc_mode_e mode;
  itc_cmd_t  cmd;
  logic      tickEn, countIsOne, countIsTwo, initOdd;

  assign mode = itc_mode_e'(modeSel);

  itc_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rstN(rstN), .cntClkIn(cntClkIn), .tickEn(tickEn)
  );

  itc_control u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn), .mode(mode),
    .loadStb(loadStb), .loadOdd(loadValue[0]), .countIsOne(countIsOne),
    .countIsTwo(countIsTwo), .initOdd(initOdd), .cmd(cmd),
    .outSig(outSig), .tcIrq(tcIrq)
  );

  itc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bcdSel(bcdSel), .loadValue(loadValue),
    .countQ(countVal), .countIsOne(countIsOne), .countIsTwo(countIsTwo),
    .initOdd(initOdd)
  );

  // R2: a closed gate freezes the count unless a load arrives
  a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!gateIn && !loadStb) |=> $stable(countVal));
  // R4: one-shot output, once high, only a load pulls it low
  a_r4_out_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ONESHOT && outSig && !loadStb) |=> outSig);
  // R4: one-shot pulse coincides with zero reached
  a_r4_irq_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ONESHOT && tcIrq) |-> (outSig && countVal == '0));
  // R5: rate-mode low pulse sits on count one
  a_r5_low_at_one: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_RATE || mode == MODE_RATE2) && !outSig) |-> (countVal == CNT_W'(1)));
  // R6: square-wave rise and interrupt go together
  a_r6_rise_irq: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SQUARE && $rose(outSig)) |-> tcIrq);
  a_r6_irq_high: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SQUARE && tcIrq) |-> outSig);
endmodule

// File: tb/sim_interval_timer_channel.sv
`timescale 1ns/1ps
module sim_interval_timer_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntClkIn = 1'b0;
  logic        gateIn = 1'b1;
  logic [1:0]  modeSel = 2'd0;
  logic        bcdSel = 1'b0;
  logic [15:0] loadValue = '0;
  logic        loadStb = 1'b0;
  logic        outSig, tcIrq;
  logic [15:0] countVal;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int sy1, sy2, sy3;
  int mCnt, mInit, mOdd, mStarted, mOut, mIrq;
  int ldN;
  int dutIrqs, refIrqs;

  always #5 clk = ~clk;

  interval_timer_channel u0 (
    .clk(clk), .rstN(rstN), .cntClkIn(cntClkIn), .gateIn(gateIn),
    .modeSel(modeSel), .bcdSel(bcdSel), .loadValue(loadValue), .loadStb(loadStb),
    .outSig(outSig), .tcIrq(tcIrq), .countVal(countVal)
  );

  function automatic int modulus();
    return bcdSel ? 10000 : 65536;
  endfunction

  function automatic logic [15:0] enc(int v);
    if (!bcdSel) return v[15:0];
    return 16'((v % 10) | ((v / 10 % 10) << 4) | ((v / 100 % 10) << 8) | ((v / 1000 % 10) << 12));
  endfunction

  function automatic int halfN(int n);
    return (n == 0) ? modulus() / 2 : n / 2;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      sy1 = 0; sy2 = 0; sy3 = 0;
      mCnt = 0; mInit = 0; mOdd = 0; mStarted = 0; mOut = 1; mIrq = 0;
    end else begin
      int tk;
      tk = (sy2 == 1 && sy3 == 0) ? 1 : 0;
      sy3 = sy2; sy2 = sy1; sy1 = int'(cntClkIn);
      mIrq = 0;
      if (loadStb) mInit = ldN;
      if (loadStb && (modeSel == 2'd0 || mStarted == 0)) begin
        mStarted = 1;
        if (modeSel == 2'd2) begin
          mCnt = halfN(ldN); mOdd = ldN % 2; mOut = 1;
        end else begin
          mCnt = ldN; mOut = (modeSel == 2'd0) ? 0 : 1;
        end
      end else if (tk == 1 && gateIn && mStarted == 1) begin
        if (modeSel == 2'd0) begin
          if (mCnt == 1 && mOut == 0) begin mOut = 1; mIrq = 1; end
          mCnt = (mCnt == 0) ? modulus() - 1 : mCnt - 1;
        end else if (modeSel == 2'd2) begin
          if (mCnt != 1) mCnt = mCnt - 1;
          else if (mOut == 1 && mOdd == 1) mOdd = 0;
          else if (mOut == 1) begin mOut = 0; mCnt = halfN(mInit); end
          else begin mOut = 1; mCnt = halfN(mInit); mOdd = mInit % 2; mIrq = 1; end
        end else begin
          if (mCnt == 1) begin mCnt = mInit; mOut = 1; mIrq = 1; end
          else begin
            if (mCnt == 2) mOut = 0;
            mCnt = (mCnt == 0) ? modulus() - 1 : mCnt - 1;
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(outSig === mOut[0], curReq, "outSig", int'(outSig), mOut);
      chk(tcIrq === mIrq[0], curReq, "tcIrq", int'(tcIrq), mIrq);
      chk(countVal === enc(mCnt), curReq, "countVal", int'(countVal), int'(enc(mCnt)));
      if (tcIrq) dutIrqs++;
      if (mIrq == 1) refIrqs++;
    end
  end

  task automatic doReset(logic [1:0] m, logic b);
    rstN = 1'b0; modeSel = m; bcdSel = b; gateIn = 1'b1; cntClkIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doLoad(int n);
    ldN = n; loadValue = enc(n); loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic edges(int k);
    repeat (k) begin
      cntClkIn = 1'b1; repeat (2) @(negedge clk);
      cntClkIn = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle before any load
    curReq = "R1";
    doReset(2'd0, 1'b0);
    chk(outSig === 1'b1, "R1", "reset outSig", int'(outSig), 1);
    chk(tcIrq === 1'b0, "R1", "reset tcIrq", int'(tcIrq), 0);
    chk(countVal === 16'h0, "R1", "reset countVal", int'(countVal), 0);
    edges(3);
    chk(countVal === 16'h0, "R1", "idle countVal", int'(countVal), 0);

    // R4 / R9: one-shot load, count, wrap
    curReq = "R4";
    doLoad(5);
    chk(countVal === 16'd5 && outSig === 1'b0, "R9", "load restart", int'(countVal), 5);
    edges(3);
    // R2: closed gate holds the count
    curReq = "R2";
    gateIn = 1'b0;
    edges(3);
    chk(countVal === 16'd2, "R2", "gate hold", int'(countVal), 2);
    gateIn = 1'b1;
    curReq = "R4";
    edges(3);
    chk(countVal === 16'hFFFF && outSig === 1'b1, "R4", "wrap past zero", int'(countVal), 16'hFFFF);
    curReq = "R9";
    doLoad(7);
    chk(outSig === 1'b0, "R9", "reload drives low", int'(outSig), 0);
    edges(9);

    // R5 / R8: rate generator with pending load
    curReq = "R5";
    doReset(2'd1, 1'b0);
    doLoad(4);
    edges(6);
    curReq = "R8";
    doLoad(6);
    edges(14);
    chk(dutIrqs == refIrqs, "R5", "irq count", dutIrqs, refIrqs);

    // R6: square wave, odd then even
    curReq = "R6";
    doReset(2'd2, 1'b0);
    doLoad(5);
    chk(countVal === 16'd2, "R6", "first half", int'(countVal), 2);
    edges(12);
    curReq = "R8";
    doLoad(6);
    edges(14);
    // R3: binary zero half-phase value
    curReq = "R3";
    doReset(2'd2, 1'b0);
    doLoad(0);
    chk(countVal === 16'h8000, "R3", "zero half", int'(countVal), 16'h8000);

    // R7 / R3: BCD one-shot of 10000 steps
    curReq = "R7";
    doReset(2'd0, 1'b1);
    doLoad(0);
    edges(1);
    chk(countVal === 16'h9999, "R7", "bcd borrow", int'(countVal), 16'h9999);
    curReq = "R3";
    edges(9998);
    chk(outSig === 1'b0, "R3", "before terminal", int'(outSig), 0);
    edges(1);
    chk(outSig === 1'b1 && countVal === 16'h0, "R3", "bcd full span", int'(countVal), 0);

    // R7 / R10: BCD rate mode across a digit borrow
    curReq = "R10";
    doReset(2'd1, 1'b1);
    dutIrqs = 0; refIrqs = 0;
    doLoad(12);
    edges(30);
    chk(dutIrqs == refIrqs && dutIrqs > 0, "R10", "bcd rate irqs", dutIrqs, refIrqs);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule